// File: doc/BRIEF.md
# Fractional Sample Rate Tick Generator

This block derives an audio sample strobe from a fast master clock by phase accumulation. A 12-bit rate word is added into a 19-bit accumulator on every clock while the generator runs. Each carry out of the accumulator becomes a strobe that lasts one clock. The average strobe rate is therefore the clock frequency times the rate word divided by 2^19. The converters and the signal processor that consume the strobe sit outside this block.

Software uses a small byte-wide register port. Two registers hold the rate word, split into a low byte and a high nibble. A control/status register holds a run bit and a read-only sticky sample flag. The run bit passes through a synchroniser before it gates the accumulator, so that starts and stops are clean. The sticky flag rises on every strobe. There are four ways to clear it:
- a chip-level soft reset;
- a stopped run bit;
- an external clear line driven by the interrupt-clear logic;
- any write to the control/status register.

Top module: `rate_tick_gen`

## Requirements
- R1: The register address selects one of four registers: 0 is the low rate register, holding rate bits 7:0; 1 is the high rate register, whose bits 3:0 hold rate bits 11:8 and whose bits 7:4 read as zero; 2 is control/status; 3 reads as zero.
- R2: Neither the chip-reset input nor any other reset changes the rate registers; after a chip reset they read back their last written values.
- R3: After a write of 1 to control bit 0 (run), the accumulator starts from zero. The first strobe is high in the cycle following rising edge number ceil(524288/SR)+2 after the write edge, where SR is the 12-bit rate word.
- R4: While running, the number of strobes in the M cycles after the synchronised start equals floor(M*SR/524288).
- R5: The strobe is never high in two consecutive cycles.
- R6: Writing run to 0 clears the accumulator and stops the strobe from the third edge after the write on. A later restart again shows the R3 latency.
- R7: The sample flag (control bit 1, also output smp_irq) is set in the cycle after each strobe and stays set until one of its clear sources acts.
- R8: Any write to the control/status register clears the flag, whatever value is written; writes to bit 1 are otherwise ignored.
- R9: The external clear input clears the flag and holds it clear while high, even across strobes.
- R10: While the run bit is 0 the flag stays clear.
- R11: The chip-reset input clears the run bit and the flag, and the strobe stops.
- R12: With a rate word of zero the generator produces no strobe.
- R13: Control/status reads return the run bit in bit 0, the flag in bit 1 and zero in bits 7:2.
- R14: After the active-low reset, the strobe, the flag and the control/status register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_rst | input | 1 | Synchronous chip-level soft reset, active high |
| ext_clr | input | 1 | Flag clear from the interrupt-clear logic, active high, level |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| smp_tick | output | 1 | One-clock sample strobe |
| smp_irq | output | 1 | Sticky sample flag |

## Verification
The hardest case to reach from the ports is a clear source that meets a strobe. The external clear must be shown to win over a strobe that arrives while it is held, not merely to clear a flag that was already set. The stimulus does this by raising the clear just after one strobe and holding it for longer than a full strobe period at the fastest rate word. It also counts that a strobe really happened under the hold, and then shows that the flag rises again once the clear is released. The exact first-strobe latency is a second hard case. It is measured edge by edge from the write of the run bit, so a missing or extra synchroniser stage or a non-zero start value would be caught.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_RATE_LO = 2'd0,
    SEL_RATE_HI = 2'd1,
    SEL_CTRL    = 2'd2,
    SEL_NONE    = 2'd3
  } reg_sel_e;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_FLAG_BIT = 1;
endpackage

// File: rtl/rtg_sync.sv
module rtg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d_i;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int RATE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata,
  output logic [RATE_W-1:0] rate_o,
  output logic              run_o,
  output logic              ctrl_wr_o
);
  localparam int HI_W = RATE_W - DATA_W;

  logic [DATA_W-1:0] lo_q, lo_d;
  logic [HI_W-1:0]   hi_q, hi_d;
  logic              lo_en, hi_en;
  logic              run_q, run_d;

  always_comb begin
    lo_en     = wr_en && (addr == SEL_RATE_LO);
    hi_en     = wr_en && (addr == SEL_RATE_HI);
    ctrl_wr_o = wr_en && (addr == SEL_CTRL);
    lo_d      = lo_en ? wdata : lo_q;
    hi_d      = hi_en ? wdata[HI_W-1:0] : hi_q;
    if (chip_rst)       run_d = 1'b0;
    else if (ctrl_wr_o) run_d = wdata[CTRL_RUN_BIT];
    else                run_d = run_q;
  end

  // Rate word storage deliberately has no reset of any kind.
  always_ff @(posedge clk) begin
    lo_q <= lo_d;
    hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      SEL_RATE_LO: rdata = lo_q;
      SEL_RATE_HI: rdata[HI_W-1:0] = hi_q;
      SEL_CTRL: begin
        rdata[CTRL_RUN_BIT]  = run_q;
        rdata[CTRL_FLAG_BIT] = flag_i;
      end
      default: rdata = '0;
    endcase
  end

  assign rate_o = {hi_q, lo_q};
  assign run_o  = run_q;

  AST_RUN_MCR: assert property (@(posedge clk) disable iff (!rst_n)
    chip_rst |=> !run_o) else $error("chip reset left run set"); // R11
  AST_RATE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_rst && !wr_en) |=> $stable(rate_o)) else $error("rate changed on chip reset"); // R2
endmodule

// File: rtl/rtg_accum.sv
module rtg_accum #(
  parameter int RATE_W = 12,
  parameter int ACC_W  = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int PAD_W = ACC_W + 1 - RATE_W;

  logic [ACC_W-1:0] acc_q, acc_d;
  logic             tick_q, tick_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum = {1'b0, acc_q} + {{PAD_W{1'b0}}, rate_i};
    if (run_i) begin
      acc_d  = sum[ACC_W-1:0];
      tick_d = sum[ACC_W];
    end else begin
      acc_d  = '0;
      tick_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o) else $error("strobe wider than one cycle"); // R5
  AST_ZERO_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_i == '0) |=> !tick_o) else $error("strobe with zero rate"); // R12
endmodule

// File: rtl/rtg_flag.sv
module rtg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    if (clr_i)      flag_d = 1'b0;
    else if (set_i) flag_d = 1'b1;
    else            flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> flag_o) else $error("strobe did not set flag"); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o) else $error("flag dropped without clear"); // R7
endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
  import rtg_pkg::*;
#(
  parameter int RATE_W      = 12,
  parameter int ACC_W       = 19,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_rst,
  input  logic              ext_clr,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              smp_tick,
  output logic              smp_irq
);
  logic              rst_sync_n;
  logic [RATE_W-1:0] rate;
  logic              run_q;
  logic              run_s;
  logic              ctrl_wr;
  logic              flag_clr;

  rtg_sync #(.STAGES(2)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d_i(1'b1), .q_o(rst_sync_n)
  );

  rtg_regs #(.RATE_W(RATE_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .chip_rst(chip_rst),
    .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .flag_i(smp_irq), .rdata(reg_rdata), .rate_o(rate),
    .run_o(run_q), .ctrl_wr_o(ctrl_wr)
  );

  rtg_sync #(.STAGES(SYNC_STAGES)) u_run_sync (
    .clk(clk), .rst_n(rst_sync_n), .d_i(run_q), .q_o(run_s)
  );

  rtg_accum #(.RATE_W(RATE_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_sync_n), .run_i(run_s), .rate_i(rate), .tick_o(smp_tick)
  );

  assign flag_clr = chip_rst | ~run_q | ext_clr | ctrl_wr;

  rtg_flag u_flag (
    .clk(clk), .rst_n(rst_sync_n), .set_i(smp_tick), .clr_i(flag_clr), .flag_o(smp_irq)
  );

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run_s |=> !smp_tick) else $error("strobe while stopped"); // R6
  AST_CTRL_WR_CLR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ctrl_wr |=> !smp_irq) else $error("control write kept flag"); // R8
  AST_EXT_CLR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_clr |=> !smp_irq) else $error("external clear kept flag"); // R9
  AST_IDLE_CLR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !run_q |=> !smp_irq) else $error("flag set while run is zero"); // R10
endmodule

// File: tb/sim_rate_tick_gen.sv
module sim_rate_tick_gen;
  localparam int CLK_PERIOD = 10;
  localparam longint FULL = 524288;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       chip_rst = 1'b0;
  logic       ext_clr = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       smp_tick;
  logic       smp_irq;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_tick_gen u0 (
    .clk(clk), .rst_n(rst_n), .chip_rst(chip_rst), .ext_clr(ext_clr),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .smp_tick(smp_tick), .smp_irq(smp_irq)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_rate(input int sr);
    wr_reg(2'd0, sr[7:0]);
    wr_reg(2'd1, {4'h0, sr[11:8]});
  endtask

  // returns index of the negedge (after the call) at which the strobe is seen, 0 if none
  task automatic wait_tick(input int limit, output int at);
    at = 0;
    for (int k = 1; k <= limit; k++) begin
      @(negedge clk);
      if (smp_tick) begin at = k; break; end
    end
  endtask

  task automatic stop_gen();
    wr_reg(2'd2, 8'h00);
    repeat (4) @(negedge clk);
  endtask

  function automatic int first_lat(input int sr);
    return int'((FULL + sr - 1) / sr) + 2;
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    chk(smp_tick == 1'b0, "R14 tick after reset", smp_tick, 0);
    chk(smp_irq == 1'b0, "R14 flag after reset", smp_irq, 0);
    rd_reg(2'd2, d);
    chk(d == 8'h00, "R14 control after reset", d, 0);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr_reg(2'd0, 8'hA5);
    wr_reg(2'd1, 8'hFF);
    rd_reg(2'd0, d);
    chk(d == 8'hA5, "R1 low rate readback", d, 8'hA5);
    rd_reg(2'd1, d);
    chk(d == 8'h0F, "R1 high rate readback", d, 8'h0F);
    rd_reg(2'd3, d);
    chk(d == 8'h00, "R1 unused address", d, 0);
    wr_reg(2'd2, 8'hFE);
    rd_reg(2'd2, d);
    chk(d == 8'h00, "R13 control bits 7:1 ignored", d, 0);
  endtask

  task automatic t_first(input int sr);
    int at;
    set_rate(sr);
    wr_reg(2'd2, 8'h01);
    wait_tick(first_lat(sr) + 20, at);
    chk(at == first_lat(sr), $sformatf("R3 first strobe sr=%0d", sr), at, first_lat(sr));
    stop_gen();
  endtask

  task automatic t_rate(input int sr, input int m);
    int cnt = 0;
    int dbl = 0;
    bit prev = 1'b0;
    longint exp;
    set_rate(sr);
    wr_reg(2'd2, 8'h01);
    repeat (2) @(negedge clk);
    for (int k = 0; k < m; k++) begin
      @(negedge clk);
      if (smp_tick) cnt++;
      if (smp_tick && prev) dbl++;
      prev = smp_tick;
    end
    exp = (longint'(m) * sr) / FULL;
    chk(cnt == exp, $sformatf("R4 strobe count sr=%0d", sr), cnt, exp);
    chk(dbl == 0, "R5 no back-to-back strobes", dbl, 0);
    stop_gen();
  endtask

  task automatic t_stop();
    int at;
    int seen = 0;
    set_rate(4095);
    wr_reg(2'd2, 8'h01);
    repeat (200) @(negedge clk);
    wr_reg(2'd2, 8'h00);
    repeat (2) @(negedge clk);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (smp_tick || smp_irq) seen++;
    end
    chk(seen == 0, "R6 R10 quiet after stop", seen, 0);
    wr_reg(2'd2, 8'h01);
    wait_tick(first_lat(4095) + 20, at);
    chk(at == first_lat(4095), "R6 restart from cleared accumulator", at, first_lat(4095));
    stop_gen();
  endtask

  task automatic t_flag();
    int at;
    int held = 0;
    int ticks = 0;
    logic [7:0] d;
    set_rate(4095);
    wr_reg(2'd2, 8'h01);
    wait_tick(400, at);
    @(negedge clk);
    chk(smp_irq == 1'b1, "R7 flag set after strobe", smp_irq, 1);
    repeat (20) @(negedge clk);
    chk(smp_irq == 1'b1, "R7 flag sticky", smp_irq, 1);
    rd_reg(2'd2, d);
    chk(d == 8'h03, "R13 control shows run and flag", d, 8'h03);
    wr_reg(2'd2, 8'h01);
    chk(smp_irq == 1'b0, "R8 control write clears flag", smp_irq, 0);
    rd_reg(2'd2, d);
    chk(d == 8'h01, "R8 run kept after clearing write", d, 8'h01);
    wait_tick(400, at);
    @(negedge clk);
    chk(smp_irq == 1'b1, "R7 flag set again", smp_irq, 1);
    ext_clr = 1'b1;
    for (int k = 0; k < 150; k++) begin
      @(negedge clk);
      if (smp_irq) held++;
      if (smp_tick) ticks++;
    end
    chk(held == 0, "R9 external clear holds flag low", held, 0);
    chk(ticks >= 1, "R9 strobe occurred during hold", ticks, 1);
    ext_clr = 1'b0;
    wait_tick(400, at);
    @(negedge clk);
    chk(smp_irq == 1'b1, "R9 flag returns after release", smp_irq, 1);
    stop_gen();
  endtask

  task automatic t_mcr();
    int at;
    int seen = 0;
    logic [7:0] d;
    set_rate(12'h9C7);
    wr_reg(2'd2, 8'h01);
    wait_tick(400, at);
    @(negedge clk);
    chip_rst = 1'b1;
    @(negedge clk);
    chip_rst = 1'b0;
    chk(smp_irq == 1'b0, "R11 chip reset clears flag", smp_irq, 0);
    rd_reg(2'd2, d);
    chk(d == 8'h00, "R11 chip reset clears run", d, 0);
    rd_reg(2'd0, d);
    chk(d == 8'hC7, "R2 low rate survives chip reset", d, 8'hC7);
    rd_reg(2'd1, d);
    chk(d == 8'h09, "R2 high rate survives chip reset", d, 8'h09);
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      if (smp_tick) seen++;
    end
    chk(seen == 0, "R11 strobe stops after chip reset", seen, 0);
  endtask

  task automatic t_zero();
    int seen = 0;
    set_rate(0);
    wr_reg(2'd2, 8'h01);
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (smp_tick || smp_irq) seen++;
    end
    chk(seen == 0, "R12 zero rate gives no strobe", seen, 0);
    stop_gen();
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_first(4095);
    t_first(2048);
    t_first(1000);
    t_rate(3000, 5000);
    t_rate(4095, 3000);
    t_stop();
    t_flag();
    t_mcr();
    t_zero();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule